// File: doc/BRIEF.md
# Interlocked Flash Mode Control Registers

This block is a byte-wide bank of peripheral registers that selects the operating mode of an on-chip flash array. It holds a mode control register, a read-only status register, two erase-block select registers and a RAM emulation select register, all placed in a 16-byte window at the top of the lower address space. Software reaches them over a simple register bus. Reads return data combinationally in the same cycle. Writes take effect at the next clock edge.

The mode bits are protected by a chain of interlocks. The external flash write-enable pin must be high before software may set the software-enable bit. Software-enable must already be set before the setup and verify bits accept writes. The matching setup bit must already be set before the erase or program action bit accepts a write. Each gate is judged on the register contents held before the write, so one write cannot climb two steps of the chain. Power-on reset, either standby input, a low pin level or a disabled flash strap clears all the mode bits. The decoded mode bits and block selects are driven straight out to the flash array controller.

Top module: `flash_mode_regs`

## Requirements
- R1: After reset the mode register reads 8'h80 when `fwe_pin` is 1 and 8'h00 when it is 0. The status register and both block registers read 8'h00, and the RAM emulation register reads 8'hF0.
- R2: The byte address map is as follows: mode register at 16'hFF40, status register at 16'hFF41 (read-only, always 8'h00), block register low at 16'hFF42 (drives `blk_sel[7:0]`), block register high at 16'hFF43 (drives `blk_sel[15:8]`) and RAM emulation at 16'hFF47. Read data follows the address combinationally. Addresses outside 16'hFF40–16'hFF4F read 8'h00 and are ignored on write.
- R3: The mode register bit layout is: bit 7 = live `fwe_pin` level (read-only), 6 = software enable, 5 = erase setup, 4 = program setup, 3 = erase verify, 2 = program verify, 1 = erase, 0 = program. Bits 6..0 drive the mode outputs of the same name.
- R4: The software-enable bit takes the written value only when `fwe_pin` is 1.
- R5: Erase setup, program setup, erase verify and program verify take the written value only when `fwe_pin` is 1 and software enable was already 1 before the write.
- R6: The erase bit takes the written value only when the pin is 1 and software enable and erase setup were both already 1. The program bit takes the written value only when the pin is 1 and software enable and program setup were both already 1.
- R7: A clock edge at which `fwe_pin` is 0 clears mode bits 6..0, whatever is being written.
- R8: A clock edge at which `hw_stby` or `sw_stby` is 1 clears mode bits 6..0. The other registers keep their values.
- R9: While `flash_en` is 0, the mode register reads 8'h00, writes to it are ignored and mode bits 6..0 are cleared at each edge.
- R10: Only `bus_size` = 0 (byte) is a valid access. With `bus_size` 1 (word), 2 (longword) or 3, a write changes no register and a read returns 8'h00.
- R11: A read or write to 16'hFF44–16'hFF46 or 16'hFF48–16'hFF4F returns 8'h00, changes nothing, and sets `acc_err` to 1 for exactly the cycle after the access. No other access sets it.
- R12: In the RAM emulation register, bits 7..4 always read 1 and bits 3..0 are writable and drive `ram_emu_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| hw_stby | input | 1 | Hardware standby, clears mode bits |
| sw_stby | input | 1 | Software standby, clears mode bits |
| fwe_pin | input | 1 | Flash write-enable pin level |
| flash_en | input | 1 | Strap: on-chip flash enabled |
| bus_addr | input | 16 | Register byte address (lower 16 bits) |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| swe_en | output | 1 | Software enable |
| erase_setup | output | 1 | Erase setup |
| prog_setup | output | 1 | Program setup |
| erase_verify | output | 1 | Erase verify |
| prog_verify | output | 1 | Program verify |
| erase_go | output | 1 | Erase action |
| prog_go | output | 1 | Program action |
| blk_sel | output | 16 | Erase block selects {high, low} |
| ram_emu_sel | output | 4 | RAM emulation select |
| acc_err | output | 1 | One-cycle pulse after a prohibited access |

## Verification
Two functions can act in the same cycle. A mode register write can land on the same edge as a clearing condition: the pin going low, a standby request or a disabled strap. Also, one write can try to set software enable and a dependent bit together. The bench forces both cases: it drives a write of all ones in the same cycle as each clearing input, and it writes multi-bit values while the chain is only partly set up. A reference model, updated edge by edge from the written rules, then shows that the clear wins and that each bit judged its gate on the old contents.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

    localparam int BYTE_W = 8;

    // access size encoding on the bus
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // mode register bit positions (bit 7 reflects the pin)
    localparam int B_PIN = 7;
    localparam int B_SWE = 6;
    localparam int B_ESU = 5;
    localparam int B_PSU = 4;
    localparam int B_EV  = 3;
    localparam int B_PV  = 2;
    localparam int B_E   = 1;
    localparam int B_P   = 0;

    // window offsets
    localparam logic [3:0] OFS_CTL  = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h1;
    localparam logic [3:0] OFS_BLK0 = 4'h2;
    localparam logic [3:0] OFS_RAM  = 4'h7;

    typedef struct packed {
        logic swe;
        logic esu;
        logic psu;
        logic ev;
        logic pv;
        logic e;
        logic p;
    } mode_t;

endpackage

// File: rtl/fmr_decode.sv
module fmr_decode
    import fmr_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] BASE    = 16'hFF40,
    parameter int          NUM_BLK = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit_ctl,
    output logic               hit_stat,
    output logic [NUM_BLK-1:0] hit_blk,
    output logic               hit_ram,
    output logic               hit_bad
);
    localparam int WIN_LSB = 4;

    logic       in_win;
    logic [3:0] ofs;

    assign in_win = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
    assign ofs    = addr[WIN_LSB-1:0];

    assign hit_ctl  = in_win && (ofs == OFS_CTL);
    assign hit_stat = in_win && (ofs == OFS_STAT);
    assign hit_ram  = in_win && (ofs == OFS_RAM);

    genvar g;
    generate
        for (g = 0; g < NUM_BLK; g++) begin : g_blk
            assign hit_blk[g] = in_win && (ofs == (OFS_BLK0 + 4'(g)));
        end
    endgenerate

    // any window offset that decodes to no register is prohibited
    assign hit_bad = in_win && !hit_ctl && !hit_stat && !hit_ram && (hit_blk == '0);

endmodule

// File: rtl/fmr_mode_ctl.sv
module fmr_mode_ctl
    import fmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_req,
    input  logic              wr_stb,
    input  logic              pin,
    input  logic [BYTE_W-1:0] wdata,
    output mode_t             mode_q
);
    mode_t s_d, s_q;

    logic gate_swe, gate_lvl1, gate_e, gate_p;

    // gates judged on contents held before the write
    assign gate_swe  = pin;
    assign gate_lvl1 = pin && s_q.swe;
    assign gate_e    = gate_lvl1 && s_q.esu;
    assign gate_p    = gate_lvl1 && s_q.psu;

    always_comb begin
        s_d = s_q;
        if (clr_req) begin
            s_d = '0;
        end else if (wr_stb) begin
            if (gate_swe) s_d.swe = wdata[B_SWE];
            if (gate_lvl1) begin
                s_d.esu = wdata[B_ESU];
                s_d.psu = wdata[B_PSU];
                s_d.ev  = wdata[B_EV];
                s_d.pv  = wdata[B_PV];
            end
            if (gate_e) s_d.e = wdata[B_E];
            if (gate_p) s_d.p = wdata[B_P];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode_q = s_q;

endmodule

// File: rtl/fmr_aux_regs.sv
module fmr_aux_regs
    import fmr_pkg::*;
#(
    parameter int NUM_BLK   = 2,
    parameter int RAM_SEL_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BLK-1:0]        wr_blk,
    input  logic                      wr_ram,
    input  logic [BYTE_W-1:0]         wdata,
    output logic [NUM_BLK*BYTE_W-1:0] blk_q,
    output logic [RAM_SEL_W-1:0]      ram_q
);
    typedef struct packed {
        logic [NUM_BLK-1:0][BYTE_W-1:0] blk;
        logic [RAM_SEL_W-1:0]           ram;
    } aux_t;

    aux_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_BLK; i++) begin
            if (wr_blk[i]) s_d.blk[i] = wdata;
        end
        if (wr_ram) s_d.ram = wdata[RAM_SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign blk_q = s_q.blk;
    assign ram_q = s_q.ram;

endmodule

// File: rtl/flash_mode_regs.sv
module flash_mode_regs
    import fmr_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'hFF40,
    parameter int          NUM_BLK   = 2,
    parameter int          RAM_SEL_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hw_stby,
    input  logic                      sw_stby,
    input  logic                      fwe_pin,
    input  logic                      flash_en,
    input  logic [15:0]               bus_addr,
    input  logic [1:0]                bus_size,
    input  logic                      bus_rd,
    input  logic                      bus_wr,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    output logic                      swe_en,
    output logic                      erase_setup,
    output logic                      prog_setup,
    output logic                      erase_verify,
    output logic                      prog_verify,
    output logic                      erase_go,
    output logic                      prog_go,
    output logic [NUM_BLK*8-1:0]      blk_sel,
    output logic [RAM_SEL_W-1:0]      ram_emu_sel,
    output logic                      acc_err
);
    localparam int                    ADDR_W   = 16;
    localparam int                    FILL_W   = BYTE_W - RAM_SEL_W;
    localparam logic [BYTE_W-1:0]     RD_IDLE  = '0;

    logic               hit_ctl, hit_stat, hit_ram, hit_bad;
    logic [NUM_BLK-1:0] hit_blk;
    logic               byte_acc, byte_wr, clr_mode;
    mode_t              mode_q;

    typedef struct packed {
        logic err;
    } top_t;

    top_t s_d, s_q;

    fmr_decode #(
        .ADDR_W  (ADDR_W),
        .BASE    (BASE_ADDR),
        .NUM_BLK (NUM_BLK)
    ) u_dec (
        .addr     (bus_addr),
        .hit_ctl  (hit_ctl),
        .hit_stat (hit_stat),
        .hit_blk  (hit_blk),
        .hit_ram  (hit_ram),
        .hit_bad  (hit_bad)
    );

    assign byte_acc = (bus_size == SZ_BYTE);
    assign byte_wr  = bus_wr && byte_acc;
    assign clr_mode = hw_stby || sw_stby || !fwe_pin || !flash_en;

    fmr_mode_ctl u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_req (clr_mode),
        .wr_stb  (byte_wr && hit_ctl && flash_en),
        .pin     (fwe_pin),
        .wdata   (bus_wdata),
        .mode_q  (mode_q)
    );

    fmr_aux_regs #(
        .NUM_BLK   (NUM_BLK),
        .RAM_SEL_W (RAM_SEL_W)
    ) u_aux (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_blk (byte_wr ? hit_blk : '0),
        .wr_ram (byte_wr && hit_ram),
        .wdata  (bus_wdata),
        .blk_q  (blk_sel),
        .ram_q  (ram_emu_sel)
    );

    // error pulse one cycle after a prohibited access
    always_comb begin
        s_d     = s_q;
        s_d.err = (bus_rd || bus_wr) && hit_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_err = s_q.err;

    // read path
    always_comb begin
        bus_rdata = RD_IDLE;
        if (byte_acc) begin
            if (hit_ctl && flash_en) begin
                bus_rdata = {fwe_pin, mode_q.swe, mode_q.esu, mode_q.psu,
                             mode_q.ev, mode_q.pv, mode_q.e, mode_q.p};
            end else if (hit_ram) begin
                bus_rdata = {{FILL_W{1'b1}}, ram_emu_sel};
            end else begin
                for (int i = 0; i < NUM_BLK; i++) begin
                    if (hit_blk[i]) bus_rdata = blk_sel[i*BYTE_W +: BYTE_W];
                end
            end
            // hit_stat and hit_bad keep RD_IDLE
        end
    end

    assign swe_en       = mode_q.swe;
    assign erase_setup  = mode_q.esu;
    assign prog_setup   = mode_q.psu;
    assign erase_verify = mode_q.ev;
    assign prog_verify  = mode_q.pv;
    assign erase_go     = mode_q.e;
    assign prog_go      = mode_q.p;

endmodule

// File: rtl/fmr_chk.sv
module fmr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hw_stby,
    input logic        sw_stby,
    input logic        fwe_pin,
    input logic        flash_en,
    input logic [15:0] bus_addr,
    input logic [1:0]  bus_size,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        swe_en,
    input logic        erase_setup,
    input logic        prog_setup,
    input logic        erase_verify,
    input logic        prog_verify,
    input logic        erase_go,
    input logic        prog_go,
    input logic [15:0] blk_sel,
    input logic        acc_err
);
    logic       any_mode;
    logic       bad_addr;

    assign any_mode = swe_en || erase_setup || prog_setup || erase_verify ||
                      prog_verify || erase_go || prog_go;
    assign bad_addr = (bus_addr[15:4] == 12'hFF4) &&
                      ((bus_addr[3:0] >= 4'h4 && bus_addr[3:0] <= 4'h6) ||
                       (bus_addr[3:0] >= 4'h8));

    // R7
    pin_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwe_pin |=> !any_mode);

    // R8
    standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_stby || sw_stby) |=> !any_mode);

    // R9
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_en |=> !any_mode);

    // R4
    swe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swe_en) |-> $past(fwe_pin));

    // R5
    esu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_setup) |-> $past(swe_en && fwe_pin));

    // R6
    erase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_go) |-> $past(erase_setup && swe_en));

    // R6
    prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_go) |-> $past(prog_setup && swe_en));

    // R10
    wide_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size != 2'd0) |=> $stable(blk_sel));

    // R11
    bad_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bad_addr) |=> acc_err);

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_err) |-> $past((bus_rd || bus_wr) && bad_addr));

endmodule

bind flash_mode_regs fmr_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_stby      (hw_stby),
    .sw_stby      (sw_stby),
    .fwe_pin      (fwe_pin),
    .flash_en     (flash_en),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .swe_en       (swe_en),
    .erase_setup  (erase_setup),
    .prog_setup   (prog_setup),
    .erase_verify (erase_verify),
    .prog_verify  (prog_verify),
    .erase_go     (erase_go),
    .prog_go      (prog_go),
    .blk_sel      (blk_sel),
    .acc_err      (acc_err)
);

// File: tb/test_flash_mode_regs.sv
`timescale 1ns/1ps
module test_flash_mode_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_stby = 1'b0, sw_stby = 1'b0;
    logic        fwe_pin = 1'b1, flash_en = 1'b1;
    logic [15:0] bus_addr = 16'h0;
    logic [1:0]  bus_size = 2'd0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        swe_en, erase_setup, prog_setup, erase_verify, prog_verify, erase_go, prog_go;
    logic [15:0] blk_sel;
    logic [3:0]  ram_emu_sel;
    logic        acc_err;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    bit [6:0] m_mode;
    bit [7:0] m_blk0, m_blk1;
    bit [3:0] m_ram;
    bit       m_err;

    always #5 clk = ~clk;

    flash_mode_regs i_flash_mode_regs (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .fwe_pin(fwe_pin), .flash_en(flash_en), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .swe_en(swe_en),
        .erase_setup(erase_setup), .prog_setup(prog_setup),
        .erase_verify(erase_verify), .prog_verify(prog_verify),
        .erase_go(erase_go), .prog_go(prog_go), .blk_sel(blk_sel),
        .ram_emu_sel(ram_emu_sel), .acc_err(acc_err)
    );

    function automatic bit is_bad(input logic [15:0] a);
        return (a[15:4] == 12'hFF4) && ((a[3:0] inside {[4'h4:4'h6]}) || a[3:0] >= 4'h8);
    endfunction

    function automatic logic [7:0] ref_read(input logic [15:0] a, input logic [1:0] sz);
        if (sz != 2'd0) return 8'h00;
        case (a)
            16'hFF40: return flash_en ? {fwe_pin, m_mode} : 8'h00;
            16'hFF42: return m_blk0;
            16'hFF43: return m_blk1;
            16'hFF47: return {4'hF, m_ram};
            default:  return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic ref_edge();
        bit [6:0] old;
        if (!rst_n) begin
            m_mode = '0; m_blk0 = '0; m_blk1 = '0; m_ram = '0; m_err = 1'b0;
            return;
        end
        m_err = (bus_rd || bus_wr) && is_bad(bus_addr);
        old = m_mode;
        if (hw_stby || sw_stby || !fwe_pin || !flash_en) begin
            m_mode = '0;
        end else if (bus_wr && bus_size == 2'd0 && bus_addr == 16'hFF40) begin
            m_mode[6] = bus_wdata[6];
            if (old[6]) m_mode[5:2] = bus_wdata[5:2];
            if (old[6] && old[5]) m_mode[1] = bus_wdata[1];
            if (old[6] && old[4]) m_mode[0] = bus_wdata[0];
        end
        if (bus_wr && bus_size == 2'd0) begin
            if (bus_addr == 16'hFF42) m_blk0 = bus_wdata;
            if (bus_addr == 16'hFF43) m_blk1 = bus_wdata;
            if (bus_addr == 16'hFF47) m_ram  = bus_wdata[3:0];
        end
    endtask

    // one bus cycle: drive, check read path, clock, check registered state
    task automatic cyc(input string tag, input bit rd, input bit wr,
                       input logic [15:0] a, input logic [7:0] d, input logic [1:0] sz);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_size = sz;
        #1;
        check(tag, "rdata", bus_rdata, ref_read(a, sz));
        @(posedge clk);
        ref_edge();
        @(negedge clk);
        check(tag, "mode", {swe_en, erase_setup, prog_setup, erase_verify,
                            prog_verify, erase_go, prog_go}, m_mode);
        check(tag, "blk_sel", blk_sel, {m_blk1, m_blk0});
        check(tag, "ram_emu_sel", ram_emu_sel, m_ram);
        check(tag, "acc_err", acc_err, m_err);
    endtask

    task automatic rd(input string tag, input logic [15:0] a);
        cyc(tag, 1'b1, 1'b0, a, 8'h00, 2'd0);
    endtask

    task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
        cyc(tag, 1'b0, 1'b1, a, d, 2'd0);
    endtask

    initial begin : watchdog
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        m_mode = '0; m_blk0 = '0; m_blk1 = '0; m_ram = '0; m_err = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset values with pin high (bit 7 = pin, R3)
        cyc("R1", 1'b1, 1'b0, 16'hFF40, 8'h00, 2'd0);
        rst_n = 1'b1;
        rd("R1", 16'hFF40); rd("R1", 16'hFF41); rd("R1", 16'hFF42);
        rd("R1", 16'hFF43); rd("R1", 16'hFF47);

        // R5 R6 one write cannot climb the chain
        wr("R5", 16'hFF40, 8'h7F); rd("R4", 16'hFF40);
        wr("R5", 16'hFF40, 8'h60); rd("R5", 16'hFF40);
        wr("R6", 16'hFF40, 8'h62); rd("R6", 16'hFF40);
        wr("R6", 16'hFF40, 8'h41); rd("R6", 16'hFF40);
        wr("R5", 16'hFF40, 8'h5C); wr("R6", 16'hFF40, 8'h51); rd("R3", 16'hFF40);

        // R7 pin drop with a write in the same cycle
        fwe_pin = 1'b0;
        wr("R7", 16'hFF40, 8'h7F); rd("R7", 16'hFF40);
        wr("R4", 16'hFF40, 8'h40); rd("R4", 16'hFF40);
        fwe_pin = 1'b1;
        wr("R4", 16'hFF40, 8'h40); wr("R5", 16'hFF40, 8'h70);

        // R8 standby clears, block regs kept
        wr("R2", 16'hFF42, 8'hA5); wr("R2", 16'hFF43, 8'h3C);
        hw_stby = 1'b1; wr("R8", 16'hFF40, 8'h7F); hw_stby = 1'b0;
        rd("R8", 16'hFF40); rd("R8", 16'hFF42);
        wr("R8", 16'hFF40, 8'h40); wr("R8", 16'hFF40, 8'h54);
        sw_stby = 1'b1; wr("R8", 16'hFF40, 8'h55); sw_stby = 1'b0;
        rd("R8", 16'hFF40);

        // R9 flash disabled
        wr("R9", 16'hFF40, 8'h40);
        flash_en = 1'b0;
        rd("R9", 16'hFF40); wr("R9", 16'hFF40, 8'h40); rd("R9", 16'hFF40);
        flash_en = 1'b1;
        rd("R9", 16'hFF40);

        // R12 R2 RAM emulation and status
        wr("R12", 16'hFF47, 8'h05); rd("R12", 16'hFF47);
        wr("R12", 16'hFF47, 8'h0A); rd("R12", 16'hFF47);
        wr("R2", 16'hFF41, 8'hFF); rd("R2", 16'hFF41);
        wr("R2", 16'hFF50, 8'hFF); rd("R2", 16'hFF50);

        // R10 non-byte accesses
        cyc("R10", 1'b0, 1'b1, 16'hFF42, 8'h11, 2'd1);
        cyc("R10", 1'b0, 1'b1, 16'hFF43, 8'h22, 2'd2);
        cyc("R10", 1'b0, 1'b1, 16'hFF47, 8'h03, 2'd3);
        cyc("R10", 1'b1, 1'b0, 16'hFF42, 8'h00, 2'd1);
        wr("R10", 16'hFF40, 8'h40);
        cyc("R10", 1'b0, 1'b1, 16'hFF40, 8'h00, 2'd2);
        rd("R10", 16'hFF40);

        // R11 prohibited addresses
        wr("R11", 16'hFF45, 8'hFF); rd("R11", 16'hFF42);
        rd("R11", 16'hFF4A); rd("R11", 16'hFF44);
        wr("R11", 16'hFF4F, 8'h00); wr("R11", 16'hFF46, 8'h12);
        cyc("R11", 1'b0, 1'b0, 16'hFF48, 8'h00, 2'd0);
        cyc("R11", 1'b0, 1'b0, 16'hFF40, 8'h00, 2'd0);

        // R1 reset with pin low
        fwe_pin = 1'b0;
        rst_n = 1'b0;
        cyc("R1", 1'b0, 1'b0, 16'hFF40, 8'h00, 2'd0);
        rst_n = 1'b1;
        rd("R1", 16'hFF40); rd("R1", 16'hFF47); rd("R1", 16'hFF43);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule